// File: doc/BRIEF.md
# Load/Store Address and Extension Unit

This unit sits between a processor's register read stage and a 32-bit data memory. For every memory instruction it forms the byte address from a base register value and an offset. The offset is either a second register or a sign-extended immediate, and the immediate can be a long 16-bit field or a short 10-bit field. When the addressing mode calls for it, the unit also produces the modified base value for write-back.

Seven addressing modes are supported:
- plain indexed;
- pre-modify and post-modify by the offset;
- step up or step down by the access size, applied before or after the access.

For stores the unit drives big-endian byte enables and places the store data on every lane. For loads it picks the addressed byte or halfword out of the returned memory word. It then sign-extends or zero-extends that value and hands it to the register file two cycles after the request. As a result, the instruction right after a load cannot see the loaded value.

Sub-word accesses that are not aligned to their size raise an alignment error. In that case the memory access and the base write-back are both suppressed.

Top module: `ldst_unit`

## Requirements
- R1: In indexed mode (req_mode 0, and the reserved code 7), mem_addr is base + offset and base_wb_en stays low.
- R2: In pre-modify mode (req_mode 1), mem_addr is base + offset, and base_wb_val carries the same value with base_wb_en high.
- R3: In post-modify mode (req_mode 2), mem_addr is the unmodified base, and base_wb_val is base + offset with base_wb_en high.
- R4: The step modes ignore the offset and step by 4, 2 or 1 for req_size 0 (word), 1 (halfword) or 2 (byte); code 3 counts as word. Codes 3 (up) and 4 (down) access the stepped base. Codes 5 (up) and 6 (down) access the old base. All four write the stepped base back.
- R5: req_offsel selects the offset. Code 0 is req_roff. Code 1 is the sign-extended 16-bit req_imm. Code 2 is the sign-extended low 10 bits of req_imm; bits above bit 9 have no effect.
- R6: mem_be is big-endian, with bit 3 standing for data bits 31:24. A byte at address low bits k enables bit 3-k. A halfword at low bits 0 enables 1100, and at low bits 2 it enables 0011. A word enables 1111.
- R7: A byte store repeats req_wdata[7:0] in all four lanes, and a halfword store repeats req_wdata[15:0] in both halves. A word store passes req_wdata unchanged.
- R8: The loaded byte or halfword is taken from the lane given by R6. It is sign-extended when req_unsigned is 0 and zero-extended when it is 1. A word load is returned unchanged.
- R9: An accepted load raises ld_valid, with ld_dest equal to req_dest, exactly two cycles after the request cycle. mem_rdata is sampled in the cycle between. Stores and idle cycles produce no ld_valid.
- R10: A halfword at an odd address, or a word whose address low bits are nonzero, raises align_err. It also forces mem_en and base_wb_en low and produces no ld_valid.
- R11: With req_valid low, mem_en, base_wb_en and align_err are all low. With req_valid high and no alignment error, mem_en is high and mem_we is the inverse of req_load.
- R12: During and right after reset, ld_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A memory instruction is presented this cycle |
| req_load | input | 1 | 1 for a load, 0 for a store |
| req_size | input | 2 | 0 word, 1 halfword, 2 byte, 3 treated as word |
| req_unsigned | input | 1 | Zero-extend a sub-word load |
| req_mode | input | 3 | Addressing mode code (see R1 to R4) |
| req_offsel | input | 2 | Offset source code (see R5) |
| req_base | input | 32 | Base register value |
| req_roff | input | 32 | Register offset |
| req_imm | input | 16 | Immediate offset field |
| req_wdata | input | 32 | Store data from the register file |
| req_dest | input | 5 | Destination register index of a load |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Write strobe qualifier |
| mem_addr | output | 32 | Byte address of the access |
| mem_be | output | 4 | Byte enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Lane-replicated store data |
| mem_rdata | input | 32 | Memory word, valid the cycle after a load strobe |
| base_wb_en | output | 1 | Write the modified base back |
| base_wb_val | output | 32 | Modified base value |
| align_err | output | 1 | Misaligned access rejected |
| ld_valid | output | 1 | Formatted load result valid |
| ld_dest | output | 5 | Destination index of the result |
| ld_data | output | 32 | Extended load result |

## Verification
The address path is purely combinational, so a wrong mode decode or a wrong step size shows up on mem_addr or base_wb_val in the same cycle as the request.

A fault in the lane or extension logic stays hidden until a later load reads the affected word. It then surfaces on ld_data two cycles after that load's request. For this reason the bench stores data and reads it back through the block.

A corrupted pipeline stage shows as ld_valid or ld_dest out of step with the load that was issued two cycles earlier.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

  typedef enum logic [1:0] {
    SZ_WORD = 2'd0,
    SZ_HALF = 2'd1,
    SZ_BYTE = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [2:0] {
    AM_INDEX    = 3'd0,
    AM_PREMOD   = 3'd1,
    AM_POSTMOD  = 3'd2,
    AM_UP_PRE   = 3'd3,
    AM_DN_PRE   = 3'd4,
    AM_UP_POST  = 3'd5,
    AM_DN_POST  = 3'd6,
    AM_RSVD     = 3'd7
  } addr_mode_e;

  typedef enum logic [1:0] {
    OFS_REG   = 2'd0,
    OFS_LONG  = 2'd1,
    OFS_SHORT = 2'd2,
    OFS_RSVD  = 2'd3
  } ofs_src_e;

  // Bytes moved by one access of the given size.
  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (acc_size_e'(sz))
      SZ_BYTE: size_bytes = 3'd1;
      SZ_HALF: size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/ldst_addr_gen.sv
module ldst_addr_gen
  import ldst_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int IMM_W   = 16,
  parameter int SHORT_W = 10
) (
  input  logic [XLEN-1:0]  base,
  input  logic [XLEN-1:0]  roff,
  input  logic [IMM_W-1:0] imm,
  input  logic [2:0]       mode,
  input  logic [1:0]       offsel,
  input  logic [1:0]       size,
  output logic [XLEN-1:0]  eff_addr,
  output logic [XLEN-1:0]  wb_val,
  output logic             wb_req
);

  function automatic logic [XLEN-1:0] ext_long(input logic [IMM_W-1:0] v);
    ext_long = {{(XLEN-IMM_W){v[IMM_W-1]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] ext_short(input logic [SHORT_W-1:0] v);
    ext_short = {{(XLEN-SHORT_W){v[SHORT_W-1]}}, v};
  endfunction

  logic [XLEN-1:0] offset;
  logic [XLEN-1:0] step;
  logic [XLEN-1:0] sum_off;
  logic [XLEN-1:0] step_up;
  logic [XLEN-1:0] step_dn;

  always_comb begin
    case (ofs_src_e'(offsel))
      OFS_LONG:  offset = ext_long(imm);
      OFS_SHORT: offset = ext_short(imm[SHORT_W-1:0]);
      default:   offset = roff;
    endcase
  end

  assign step    = XLEN'(size_bytes(size));
  assign sum_off = base + offset;
  assign step_up = base + step;
  assign step_dn = base - step;

  always_comb begin
    eff_addr = sum_off;
    wb_val   = sum_off;
    wb_req   = 1'b0;
    case (addr_mode_e'(mode))
      AM_PREMOD:  wb_req = 1'b1;
      AM_POSTMOD: begin eff_addr = base;    wb_req = 1'b1; end
      AM_UP_PRE:  begin eff_addr = step_up; wb_val = step_up; wb_req = 1'b1; end
      AM_DN_PRE:  begin eff_addr = step_dn; wb_val = step_dn; wb_req = 1'b1; end
      AM_UP_POST: begin eff_addr = base;    wb_val = step_up; wb_req = 1'b1; end
      AM_DN_POST: begin eff_addr = base;    wb_val = step_dn; wb_req = 1'b1; end
      default:    ;
    endcase
  end

endmodule

// File: rtl/ldst_lane_ctl.sv
module ldst_lane_ctl
  import ldst_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int LANES = XLEN / 8,
  localparam int LSB_W = $clog2(LANES)
) (
  input  logic [LSB_W-1:0] addr_lo,
  input  logic [1:0]       size,
  input  logic [XLEN-1:0]  st_data,
  output logic [LANES-1:0] be,
  output logic [XLEN-1:0]  wdata,
  output logic             misaligned
);

  localparam logic [LANES-1:0] TOP_BYTE = {1'b1, {(LANES-1){1'b0}}};
  localparam logic [LANES-1:0] TOP_HALF = {2'b11, {(LANES-2){1'b0}}};

  logic [LSB_W-1:0] half_lo;
  assign half_lo = {addr_lo[LSB_W-1:1], 1'b0};

  always_comb begin
    case (acc_size_e'(size))
      SZ_BYTE: begin
        be         = TOP_BYTE >> addr_lo;
        wdata      = {LANES{st_data[7:0]}};
        misaligned = 1'b0;
      end
      SZ_HALF: begin
        be         = TOP_HALF >> half_lo;
        wdata      = {(LANES/2){st_data[15:0]}};
        misaligned = addr_lo[0];
      end
      default: begin
        be         = {LANES{1'b1}};
        wdata      = st_data;
        misaligned = |addr_lo;
      end
    endcase
  end

endmodule

// File: rtl/ldst_load_fmt.sv
module ldst_load_fmt
  import ldst_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int RAW  = 5,
  localparam int LANES = XLEN / 8,
  localparam int LSB_W = $clog2(LANES),
  localparam int SH_W  = $clog2(XLEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic [1:0]       size,
  input  logic             uns,
  input  logic [LSB_W-1:0] lane,
  input  logic [RAW-1:0]   dest,
  input  logic [XLEN-1:0]  rdata,
  output logic             ld_valid,
  output logic [RAW-1:0]   ld_dest,
  output logic [XLEN-1:0]  ld_data
);

  logic             s1_v;
  logic [1:0]       s1_size;
  logic             s1_uns;
  logic [LSB_W-1:0] s1_lane;
  logic [RAW-1:0]   s1_dest;

  // Request stage: memory sees the strobe, the unit remembers the format.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s1_size <= '0;
      s1_uns  <= 1'b0;
      s1_lane <= '0;
      s1_dest <= '0;
    end else begin
      s1_v    <= issue;
      s1_size <= size;
      s1_uns  <= uns;
      s1_lane <= lane;
      s1_dest <= dest;
    end
  end

  logic [SH_W-1:0] shamt;
  logic [XLEN-1:0] aligned;
  logic [XLEN-1:0] shaped;

  always_comb begin
    case (acc_size_e'(s1_size))
      SZ_BYTE: shamt = SH_W'((LANES - 1 - int'(s1_lane)) * 8);
      SZ_HALF: shamt = SH_W'((LANES - 2 - int'({s1_lane[LSB_W-1:1], 1'b0})) * 8);
      default: shamt = '0;
    endcase
  end

  assign aligned = rdata >> shamt;

  always_comb begin
    case (acc_size_e'(s1_size))
      SZ_BYTE: shaped = {{(XLEN-8){~s1_uns & aligned[7]}}, aligned[7:0]};
      SZ_HALF: shaped = {{(XLEN-16){~s1_uns & aligned[15]}}, aligned[15:0]};
      default: shaped = aligned;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_valid <= 1'b0;
      ld_dest  <= '0;
      ld_data  <= '0;
    end else begin
      ld_valid <= s1_v;
      ld_dest  <= s1_dest;
      ld_data  <= shaped;
    end
  end

  // R9: a result appears only two cycles after an accepted load.
  assert_ld_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> $past(issue, 2));

  // R9: each accepted load yields a result two cycles later.
  assert_ld_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> s1_v);

endmodule

// File: rtl/ldst_unit.sv
module ldst_unit
  import ldst_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int IMM_W   = 16,
  parameter int SHORT_W = 10,
  parameter int RAW     = 5,
  localparam int LANES  = XLEN / 8,
  localparam int LSB_W  = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_load,
  input  logic [1:0]       req_size,
  input  logic             req_unsigned,
  input  logic [2:0]       req_mode,
  input  logic [1:0]       req_offsel,
  input  logic [XLEN-1:0]  req_base,
  input  logic [XLEN-1:0]  req_roff,
  input  logic [IMM_W-1:0] req_imm,
  input  logic [XLEN-1:0]  req_wdata,
  input  logic [RAW-1:0]   req_dest,
  output logic             mem_en,
  output logic             mem_we,
  output logic [XLEN-1:0]  mem_addr,
  output logic [LANES-1:0] mem_be,
  output logic [XLEN-1:0]  mem_wdata,
  input  logic [XLEN-1:0]  mem_rdata,
  output logic             base_wb_en,
  output logic [XLEN-1:0]  base_wb_val,
  output logic             align_err,
  output logic             ld_valid,
  output logic [RAW-1:0]   ld_dest,
  output logic [XLEN-1:0]  ld_data
);

  logic [XLEN-1:0] eff_addr;
  logic            wb_req;
  logic            misaligned;
  logic            access_ok;
  logic            load_issue;

  ldst_addr_gen #(.XLEN(XLEN), .IMM_W(IMM_W), .SHORT_W(SHORT_W)) u_agen (
    .base     (req_base),
    .roff     (req_roff),
    .imm      (req_imm),
    .mode     (req_mode),
    .offsel   (req_offsel),
    .size     (req_size),
    .eff_addr (eff_addr),
    .wb_val   (base_wb_val),
    .wb_req   (wb_req)
  );

  ldst_lane_ctl #(.XLEN(XLEN)) u_lane (
    .addr_lo    (eff_addr[LSB_W-1:0]),
    .size       (req_size),
    .st_data    (req_wdata),
    .be         (mem_be),
    .wdata      (mem_wdata),
    .misaligned (misaligned)
  );

  assign access_ok  = req_valid & ~misaligned;
  assign load_issue = access_ok & req_load;
  assign mem_en     = access_ok;
  assign mem_we     = ~req_load;
  assign mem_addr   = eff_addr;
  assign base_wb_en = access_ok & wb_req;
  assign align_err  = req_valid & misaligned;

  ldst_load_fmt #(.XLEN(XLEN), .RAW(RAW)) u_fmt (
    .clk      (clk),
    .rst_n    (rst_n),
    .issue    (load_issue),
    .size     (req_size),
    .uns      (req_unsigned),
    .lane     (eff_addr[LSB_W-1:0]),
    .dest     (req_dest),
    .rdata    (mem_rdata),
    .ld_valid (ld_valid),
    .ld_dest  (ld_dest),
    .ld_data  (ld_data)
  );

  // R10: a rejected access never strobes memory or the base register.
  assert_align_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> (!mem_en && !base_wb_en));

  // R11: nothing happens without a request.
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!mem_en && !base_wb_en && !align_err));

  // R1: indexed mode leaves the base alone.
  assert_index_no_wb_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_mode == AM_INDEX)) |-> !base_wb_en);

  // R6: a byte access enables one lane, a halfword two.
  assert_byte_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && (req_size == SZ_BYTE)) |-> ($countones(mem_be) == 1));
  assert_half_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && (req_size == SZ_HALF)) |-> ($countones(mem_be) == 2));

endmodule

// File: tb/sim_ldst_unit.sv
`timescale 1ns/1ps
module sim_ldst_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_load = 1'b0, req_unsigned = 1'b0;
  logic [1:0]  req_size = '0, req_offsel = '0;
  logic [2:0]  req_mode = '0;
  logic [31:0] req_base = '0, req_roff = '0, req_wdata = '0;
  logic [15:0] req_imm = '0;
  logic [4:0]  req_dest = '0;
  logic        mem_en, mem_we, base_wb_en, align_err, ld_valid;
  logic [31:0] mem_addr, mem_wdata, base_wb_val, ld_data;
  logic [31:0] mem_rdata = '0;
  logic [3:0]  mem_be;
  logic [4:0]  ld_dest;

  always #2.5 clk = ~clk;

  ldst_unit u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_load(req_load),
    .req_size(req_size), .req_unsigned(req_unsigned), .req_mode(req_mode),
    .req_offsel(req_offsel), .req_base(req_base), .req_roff(req_roff),
    .req_imm(req_imm), .req_wdata(req_wdata), .req_dest(req_dest),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .base_wb_en(base_wb_en),
    .base_wb_val(base_wb_val), .align_err(align_err), .ld_valid(ld_valid),
    .ld_dest(ld_dest), .ld_data(ld_data)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural 16-word memory.
  logic [31:0] mem_m [16];
  initial for (int i = 0; i < 16; i++) mem_m[i] = 32'h807F_F001 + i * 32'h0101_0101;

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        for (int l = 0; l < 4; l++)
          if (mem_be[l]) mem_m[mem_addr[5:2]][l*8 +: 8] <= mem_wdata[l*8 +: 8];
      end else begin
        mem_rdata <= mem_m[mem_addr[5:2]];
      end
    end
  end

  // Reference model evaluated every cycle.
  logic [31:0] e_off, e_addr, e_wbv, e_wd, e_ld, e_w;
  logic [3:0]  e_be;
  logic [7:0]  e_b;
  logic [15:0] e_h;
  logic        e_wb, e_mis, e_en;
  int          e_step, e_lane;
  string       e_tag;
  logic        h1v = 0, h2v = 0;
  logic [4:0]  h1d, h2d;
  logic [31:0] h1x, h2x;

  always @(negedge clk) begin
    if (!rst_n) begin
      h1v = 0; h2v = 0;
    end else if (!done) begin
      case (req_offsel)
        2'd1:    e_off = 32'($signed(req_imm));
        2'd2:    e_off = 32'($signed(req_imm[9:0]));
        default: e_off = req_roff;
      endcase
      e_step = (req_size == 2) ? 1 : (req_size == 1) ? 2 : 4;
      e_wb = 1; e_wbv = 0;
      case (req_mode)
        3'd1: begin e_addr = req_base + e_off; e_wbv = e_addr; e_tag = "R2"; end
        3'd2: begin e_addr = req_base; e_wbv = req_base + e_off; e_tag = "R3"; end
        3'd3: begin e_wbv = req_base + e_step; e_addr = e_wbv; e_tag = "R4"; end
        3'd4: begin e_wbv = req_base - e_step; e_addr = e_wbv; e_tag = "R4"; end
        3'd5: begin e_addr = req_base; e_wbv = req_base + e_step; e_tag = "R4"; end
        3'd6: begin e_addr = req_base; e_wbv = req_base - e_step; e_tag = "R4"; end
        default: begin e_addr = req_base + e_off; e_wb = 0; e_tag = "R1"; end
      endcase
      if (req_offsel != 0 && req_mode < 3) e_tag = {e_tag, " R5"};
      e_mis = (req_size == 1) ? e_addr[0] : (req_size == 2) ? 1'b0 : (e_addr[1:0] != 0);
      e_en  = req_valid && !e_mis;
      e_lane = int'(e_addr[1:0]);
      case (req_size)
        2'd2: begin e_be = 4'b1000 >> e_lane; e_wd = {4{req_wdata[7:0]}}; end
        2'd1: begin e_be = e_addr[1] ? 4'b0011 : 4'b1100; e_wd = {2{req_wdata[15:0]}}; end
        default: begin e_be = 4'b1111; e_wd = req_wdata; end
      endcase
      e_w = mem_m[e_addr[5:2]];
      e_b = e_w[31 - 8*e_lane -: 8];
      e_h = e_addr[1] ? e_w[15:0] : e_w[31:16];
      case (req_size)
        2'd2: e_ld = req_unsigned ? {24'd0, e_b} : {{24{e_b[7]}}, e_b};
        2'd1: e_ld = req_unsigned ? {16'd0, e_h} : {{16{e_h[15]}}, e_h};
        default: e_ld = e_w;
      endcase

      chk(e_mis ? "R10 mem_en" : "R11 mem_en", mem_en, e_en);
      chk(e_mis ? "R10 align_err" : "R11 align_err", align_err, req_valid && e_mis);
      chk({e_tag, " wb_en"}, base_wb_en, e_en && e_wb);
      if (e_en) begin
        chk({e_tag, " addr"}, mem_addr, e_addr);
        chk("R11 mem_we", mem_we, !req_load);
        chk("R6 mem_be", mem_be, e_be);
        if (e_wb) chk({e_tag, " wb_val"}, base_wb_val, e_wbv);
        if (!req_load) chk("R7 mem_wdata", mem_wdata, e_wd);
      end
      chk("R9 ld_valid", ld_valid, h2v);
      if (h2v) begin
        chk("R9 ld_dest", ld_dest, h2d);
        chk("R8 ld_data", ld_data, h2x);
      end
      h2v = h1v; h2d = h1d; h2x = h1x;
      h1v = e_en && req_load; h1d = req_dest; h1x = e_ld;
    end
  end

  task automatic go(input logic ld, input logic [1:0] sz, input logic uns,
                    input logic [2:0] md, input logic [1:0] os, input logic [31:0] b,
                    input logic [31:0] ro, input logic [15:0] im, input logic [31:0] wd,
                    input logic [4:0] dst);
    @(posedge clk); #1;
    req_valid = 1; req_load = ld; req_size = sz; req_unsigned = uns; req_mode = md;
    req_offsel = os; req_base = b; req_roff = ro; req_imm = im; req_wdata = wd; req_dest = dst;
  endtask

  task automatic idle();
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  logic [31:0] lfsr = 32'h1234_5679;

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 ld_valid in reset", ld_valid, 0);
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    chk("R12 ld_valid after reset", ld_valid, 0);
    chk("R11 idle mem_en", mem_en, 0);
    // R7 stores: byte, halfword, word
    go(0, 2, 0, 0, 0, 32'h100, 32'h1, 16'h0, 32'hA5A5_A5C3, 0);
    go(0, 1, 0, 0, 1, 32'h108, 0, 16'h0002, 32'h0000_9ABC, 0);
    go(0, 0, 0, 0, 0, 32'h110, 32'h0, 16'h0, 32'hDEAD_BEEF, 0);
    // R8 signed/unsigned reads of those values
    go(1, 2, 0, 0, 0, 32'h101, 0, 0, 0, 5'd3);
    go(1, 2, 1, 0, 0, 32'h101, 0, 0, 0, 5'd4);
    go(1, 1, 0, 0, 0, 32'h10A, 0, 0, 0, 5'd5);
    go(1, 1, 1, 0, 0, 32'h10A, 0, 0, 0, 5'd6);
    go(1, 0, 0, 0, 0, 32'h110, 0, 0, 0, 5'd7);
    // R5 short immediate with upper bits set, long negative immediate
    go(1, 2, 0, 1, 2, 32'h1000, 0, 16'hFE05, 0, 5'd8);
    go(1, 0, 0, 2, 1, 32'h1000, 0, 16'hFFFC, 0, 5'd9);
    // R4 steps for each size
    for (int s = 0; s < 3; s++)
      for (int m = 3; m < 7; m++)
        go(1, 2'(s), 0, 3'(m), 0, 32'h200, 32'h55, 0, 0, 5'(m));
    // R10 misaligned halfword and word
    go(1, 1, 0, 1, 0, 32'h300, 32'h3, 0, 0, 5'd1);
    go(0, 0, 0, 5, 0, 32'h302, 0, 0, 32'h1, 0);
    idle();
    idle();
    for (int i = 0; i < 1500; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (lfsr[9:8] == 2'b00) idle();
      else go(lfsr[0], lfsr[2:1], lfsr[3], lfsr[6:4], lfsr[11:10],
              {lfsr[31:20], 4'h0, lfsr[19:18], 2'b00}, {26'd0, lfsr[17:12]},
              lfsr[27:12], lfsr, lfsr[16:12]);
    end
    idle();
    repeat (4) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule